// File: doc/BRIEF.md
# Double-Precision Sign, Compare and Classify Unit

This unit carries out the non-arithmetic operations on IEEE-754 binary64 values that a floating-point pipeline needs next to its adders and multipliers. It covers three flavours of sign injection, minimum and maximum with defined NaN handling, the three ordered and equality comparisons, a ten-bit category mask, and raw bit moves between the floating-point and integer register files. It does no rounding, no arithmetic and no format conversion.

An operation is presented as two 64-bit operands, a 3-bit operation group and a 3-bit sub-function code, qualified by a valid strobe. One clock later the unit shows a valid strobe together with the floating-point result or the integer result, a flag that says which register file receives it, an invalid-operation flag and an illegal-instruction flag. Operand A feeds moves and classification. Operand B is used only by the two-operand groups.

Top module: `dpfp_misc_unit`

## Requirements
- R1: `valid_o` equals `valid_i` from the previous clock. All outputs change only on a clock where `valid_i` was high and otherwise hold. Reset clears `valid_o` and all result and flag outputs to 0.
- R2: Group 0 (sign injection) returns bits 62:0 of operand A. Bit 63 is B's sign for sub 0, the inverse of B's sign for sub 1, and A's sign XOR B's sign for sub 2.
- R3: Group 1, sub 0 (minimum) returns A if B is any NaN or if A is less than B in a quiet compare. Otherwise it returns B.
- R4: Group 1, sub 1 (maximum) returns A if B is any NaN or if B is less than or equal to A in a quiet compare. Otherwise it returns B.
- R5: Group 2 compares A with B. Sub 0 is less-or-equal, sub 1 is less-than and sub 2 is equal. The result is 0 or 1 in `int_res_o`, with `int_dst_o` = 1. Any comparison that involves a NaN yields 0.
- R6: +0 and -0 compare equal, and less-than between them returns 0 in either order.
- R7: Less-or-equal and less-than raise `invalid_o` when either operand is any NaN. Equal raises it only when an operand is a signaling NaN.
- R8: Minimum and maximum raise `invalid_o` only when an operand is a signaling NaN.
- R9: Group 3, sub 1 returns in `int_res_o` a zero-extended mask that is one-hot over bits 9:0: 0 -inf, 1 -normal, 2 -subnormal, 3 -zero, 4 +zero, 5 +subnormal, 6 +normal, 7 +inf, 8 signaling NaN, 9 quiet NaN.
- R10: A NaN has exponent bits 62:52 all ones and fraction bits 51:0 nonzero. It is signaling when bit 51 is 0 and quiet when bit 51 is 1. An all-ones exponent with a zero fraction is infinity, and an all-zero exponent is zero or subnormal.
- R11: Group 3, sub 0 copies A unchanged to `int_res_o` with `int_dst_o` = 1. Group 4, sub 0 copies A unchanged to `fp_res_o` with `int_dst_o` = 0.
- R12: Group codes 5 to 7 and undefined sub codes raise `illegal_o` and return zero results with `invalid_o` and `int_dst_o` at 0. The undefined sub codes are 3 to 7 for group 0, 2 to 7 for groups 1 and 3, 3 to 7 for group 2, and 1 to 7 for group 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present |
| grp_i | input | 3 | Operation group |
| sub_i | input | 3 | Sub-function code |
| op_a_i | input | 64 | Operand A (FP value or integer source for a move) |
| op_b_i | input | 64 | Operand B |
| valid_o | output | 1 | Result present |
| fp_res_o | output | 64 | Result for the FP register file |
| int_res_o | output | 64 | Result for the integer register file |
| int_dst_o | output | 1 | Result goes to the integer file |
| invalid_o | output | 1 | Invalid-operation flag |
| illegal_o | output | 1 | Illegal-instruction flag |

## Verification
The hardest conditions to reach are the NaN and signed-zero corners. These include a signaling NaN in only one operand of an equality or a minimum, a NaN in operand A alone where minimum must still return B, and +0 against -0 in both orders. Random 64-bit patterns almost never produce them. The stimulus therefore crosses a fixed set of eleven special and ordinary values in every ordered pair for every compare, min/max and sign sub-code, and then sweeps every undefined group and sub code.

// File: rtl/dpfp_pkg.sv
package dpfp_pkg;
  typedef enum logic [2:0] {
    GRP_SGNJ   = 3'd0,
    GRP_MINMAX = 3'd1,
    GRP_CMP    = 3'd2,
    GRP_TOINT  = 3'd3,
    GRP_TOFP   = 3'd4
  } grp_e;

  localparam int unsigned CLS_W      = 10;
  localparam int unsigned CLS_NINF   = 0;
  localparam int unsigned CLS_NNORM  = 1;
  localparam int unsigned CLS_NSUB   = 2;
  localparam int unsigned CLS_NZERO  = 3;
  localparam int unsigned CLS_PZERO  = 4;
  localparam int unsigned CLS_PSUB   = 5;
  localparam int unsigned CLS_PNORM  = 6;
  localparam int unsigned CLS_PINF   = 7;
  localparam int unsigned CLS_SNAN   = 8;
  localparam int unsigned CLS_QNAN   = 9;
endpackage

// File: rtl/dpfp_classify.sv
module dpfp_classify
  import dpfp_pkg::*;
#(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] val_i,
  output logic [CLS_W-1:0]  cls_o
);
  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic exp_ones, exp_zero, frac_nz, finite_nz;

  assign sgn       = val_i[WORD_W-1];
  assign ex        = val_i[WORD_W-2:FRAC_W];
  assign fr        = val_i[FRAC_W-1:0];
  assign exp_ones  = &ex;
  assign exp_zero  = ~|ex;
  assign frac_nz   = |fr;
  assign finite_nz = ~exp_ones & ~exp_zero;

  always_comb begin
    cls_o            = '0;
    cls_o[CLS_NINF]  =  sgn & exp_ones & ~frac_nz;
    cls_o[CLS_NNORM] =  sgn & finite_nz;
    cls_o[CLS_NSUB]  =  sgn & exp_zero & frac_nz;
    cls_o[CLS_NZERO] =  sgn & exp_zero & ~frac_nz;
    cls_o[CLS_PZERO] = ~sgn & exp_zero & ~frac_nz;
    cls_o[CLS_PSUB]  = ~sgn & exp_zero & frac_nz;
    cls_o[CLS_PNORM] = ~sgn & finite_nz;
    cls_o[CLS_PINF]  = ~sgn & exp_ones & ~frac_nz;
    // quiet bit is the fraction MSB
    cls_o[CLS_SNAN]  = exp_ones & frac_nz & ~fr[FRAC_W-1];
    cls_o[CLS_QNAN]  = exp_ones & fr[FRAC_W-1];
  end
endmodule

// File: rtl/dpfp_order.sv
module dpfp_order #(
  parameter int unsigned WORD_W = 64
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              any_nan_i,
  input  logic              both_zero_i,
  output logic              lt_o,
  output logic              eq_o
);
  logic              sa, sb;
  logic [WORD_W-2:0] ma, mb;

  assign sa = a_i[WORD_W-1];
  assign sb = b_i[WORD_W-1];
  assign ma = a_i[WORD_W-2:0];
  assign mb = b_i[WORD_W-2:0];

  always_comb begin
    if (any_nan_i) begin
      lt_o = 1'b0;
      eq_o = 1'b0;
    end else if (both_zero_i) begin
      lt_o = 1'b0;
      eq_o = 1'b1;
    end else if (sa != sb) begin
      lt_o = sa;
      eq_o = 1'b0;
    end else begin
      // sign-magnitude: negative values order by reversed magnitude
      lt_o = sa ? (ma > mb) : (ma < mb);
      eq_o = (ma == mb);
    end
  end
endmodule

// File: rtl/dpfp_sgnj.sv
module dpfp_sgnj #(
  parameter int unsigned WORD_W = 64
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [1:0]        mode_i,
  output logic [WORD_W-1:0] res_o
);
  logic new_sgn;

  always_comb begin
    unique case (mode_i)
      2'd0:    new_sgn = b_i[WORD_W-1];
      2'd1:    new_sgn = ~b_i[WORD_W-1];
      default: new_sgn = a_i[WORD_W-1] ^ b_i[WORD_W-1];
    endcase
  end

  assign res_o = {new_sgn, a_i[WORD_W-2:0]};
endmodule

// File: rtl/dpfp_misc_unit.sv
module dpfp_misc_unit
  import dpfp_pkg::*;
#(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W,
  localparam int unsigned NOPS   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        grp_i,
  input  logic [2:0]        sub_i,
  input  logic [WORD_W-1:0] op_a_i,
  input  logic [WORD_W-1:0] op_b_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] fp_res_o,
  output logic [WORD_W-1:0] int_res_o,
  output logic              int_dst_o,
  output logic              invalid_o,
  output logic              illegal_o
);
  logic [WORD_W-1:0] ops [NOPS];
  logic [CLS_W-1:0]  cls [NOPS];
  logic [NOPS-1:0]   is_nan, is_snan, is_zero;

  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;

  for (genvar i = 0; i < NOPS; i++) begin : g_cls
    dpfp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .val_i (ops[i]),
      .cls_o (cls[i])
    );
    assign is_nan[i]  = cls[i][CLS_SNAN] | cls[i][CLS_QNAN];
    assign is_snan[i] = cls[i][CLS_SNAN];
    assign is_zero[i] = cls[i][CLS_NZERO] | cls[i][CLS_PZERO];
  end

  logic unused_cls_b;
  assign unused_cls_b = ^{cls[1][CLS_PINF:CLS_PSUB], cls[1][CLS_NSUB:CLS_NINF]};

  logic a_lt_b, a_eq_b, b_lt_a, b_eq_a;

  dpfp_order #(.WORD_W(WORD_W)) u_ord_ab (
    .a_i         (op_a_i),
    .b_i         (op_b_i),
    .any_nan_i   (|is_nan),
    .both_zero_i (&is_zero),
    .lt_o        (a_lt_b),
    .eq_o        (a_eq_b)
  );

  dpfp_order #(.WORD_W(WORD_W)) u_ord_ba (
    .a_i         (op_b_i),
    .b_i         (op_a_i),
    .any_nan_i   (|is_nan),
    .both_zero_i (&is_zero),
    .lt_o        (b_lt_a),
    .eq_o        (b_eq_a)
  );

  logic [WORD_W-1:0] sgnj_res;

  dpfp_sgnj #(.WORD_W(WORD_W)) u_sgnj (
    .a_i    (op_a_i),
    .b_i    (op_b_i),
    .mode_i (sub_i[1:0]),
    .res_o  (sgnj_res)
  );

  logic [WORD_W-1:0] fp_d, int_d;
  logic              to_int_d, inv_d, ill_d;

  always_comb begin
    fp_d     = '0;
    int_d    = '0;
    to_int_d = 1'b0;
    inv_d    = 1'b0;
    ill_d    = 1'b0;
    unique case (grp_i)
      GRP_SGNJ: begin
        if (sub_i <= 3'd2) fp_d = sgnj_res;
        else               ill_d = 1'b1;
      end
      GRP_MINMAX: begin
        if (sub_i == 3'd0) begin
          fp_d  = (is_nan[1] || a_lt_b) ? op_a_i : op_b_i;
          inv_d = |is_snan;
        end else if (sub_i == 3'd1) begin
          fp_d  = (is_nan[1] || b_lt_a || b_eq_a) ? op_a_i : op_b_i;
          inv_d = |is_snan;
        end else begin
          ill_d = 1'b1;
        end
      end
      GRP_CMP: begin
        to_int_d = 1'b1;
        unique case (sub_i)
          3'd0: begin
            int_d[0] = a_lt_b | a_eq_b;
            inv_d    = |is_nan;
          end
          3'd1: begin
            int_d[0] = a_lt_b;
            inv_d    = |is_nan;
          end
          3'd2: begin
            int_d[0] = a_eq_b;
            inv_d    = |is_snan;
          end
          default: begin
            to_int_d = 1'b0;
            ill_d    = 1'b1;
          end
        endcase
      end
      GRP_TOINT: begin
        if (sub_i == 3'd0) begin
          int_d    = op_a_i;
          to_int_d = 1'b1;
        end else if (sub_i == 3'd1) begin
          int_d    = {{(WORD_W-CLS_W){1'b0}}, cls[0]};
          to_int_d = 1'b1;
        end else begin
          ill_d = 1'b1;
        end
      end
      GRP_TOFP: begin
        if (sub_i == 3'd0) fp_d = op_a_i;
        else               ill_d = 1'b1;
      end
      default: ill_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      fp_res_o  <= '0;
      int_res_o <= '0;
      int_dst_o <= 1'b0;
      invalid_o <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        fp_res_o  <= fp_d;
        int_res_o <= int_d;
        int_dst_o <= to_int_d;
        invalid_o <= inv_d;
        illegal_o <= ill_d;
      end
    end
  end
endmodule

// File: rtl/dpfp_misc_chk.sv
module dpfp_misc_chk #(
  parameter int unsigned WORD_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        grp_i,
  input logic [2:0]        sub_i,
  input logic [WORD_W-1:0] op_a_i,
  input logic [WORD_W-1:0] op_b_i,
  input logic              valid_o,
  input logic [WORD_W-1:0] fp_res_o,
  input logic [WORD_W-1:0] int_res_o,
  input logic              int_dst_o,
  input logic              invalid_o,
  input logic              illegal_o
);
  // R1
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(fp_res_o) && $stable(int_res_o) && $stable(illegal_o));

  // R2
  sgnj_mag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && grp_i == 3'd0 && sub_i <= 3'd2 |=>
      fp_res_o[WORD_W-2:0] == $past(op_a_i[WORD_W-2:0]) && !illegal_o);

  // R3
  minmax_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && grp_i == 3'd1 && sub_i <= 3'd1 |=>
      fp_res_o == $past(op_a_i) || fp_res_o == $past(op_b_i));

  // R5
  cmp_bool_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && grp_i == 3'd2 && sub_i <= 3'd2 |=>
      int_res_o[WORD_W-1:1] == '0 && int_dst_o && !illegal_o);

  // R9
  cls_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && grp_i == 3'd3 && sub_i == 3'd1 |=>
      $countones(int_res_o[9:0]) == 1 && int_res_o[WORD_W-1:10] == '0);

  // R12
  illegal_grp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && grp_i > 3'd4 |=>
      illegal_o && !invalid_o && !int_dst_o && fp_res_o == '0 && int_res_o == '0);
endmodule

bind dpfp_misc_unit dpfp_misc_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/dpfp_misc_unit_tb.sv
module dpfp_misc_unit_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVAL = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  grp_i = '0;
  logic [2:0]  sub_i = '0;
  logic [63:0] op_a_i = '0;
  logic [63:0] op_b_i = '0;
  logic        valid_o;
  logic [63:0] fp_res_o, int_res_o;
  logic        int_dst_o, invalid_o, illegal_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpfp_misc_unit u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .valid_i   (valid_i),
    .grp_i     (grp_i),
    .sub_i     (sub_i),
    .op_a_i    (op_a_i),
    .op_b_i    (op_b_i),
    .valid_o   (valid_o),
    .fp_res_o  (fp_res_o),
    .int_res_o (int_res_o),
    .int_dst_o (int_dst_o),
    .invalid_o (invalid_o),
    .illegal_o (illegal_o)
  );

  typedef struct {
    logic [63:0] fp;
    logic [63:0] ir;
    logic        dst;
    logic        inv;
    logic        ill;
    string       req;
  } exp_t;

  exp_t sb_q[$];

  logic [63:0] vals [NVAL];
  initial begin
    vals[0]  = 64'h3FF0_0000_0000_0000; // +1
    vals[1]  = 64'hBFF0_0000_0000_0000; // -1
    vals[2]  = 64'h4000_0000_0000_0000; // +2
    vals[3]  = 64'hC000_0000_0000_0000; // -2
    vals[4]  = 64'h0000_0000_0000_0000; // +0
    vals[5]  = 64'h8000_0000_0000_0000; // -0
    vals[6]  = 64'h7FF0_0000_0000_0000; // +inf
    vals[7]  = 64'hFFF0_0000_0000_0000; // -inf
    vals[8]  = 64'h7FF8_0000_0000_0001; // qnan
    vals[9]  = 64'hFFF4_0000_0000_0000; // snan
    vals[10] = 64'h8000_0000_0000_0001; // -subnormal
  end

  function automatic bit m_nan(logic [63:0] x);
    return x[62:52] == 11'h7FF && x[51:0] != 0;
  endfunction
  function automatic bit m_snan(logic [63:0] x);
    return m_nan(x) && !x[51];
  endfunction
  function automatic bit m_zero(logic [63:0] x);
    return x[62:0] == 0;
  endfunction
  // monotone unsigned key for non-NaN values
  function automatic logic [63:0] m_key(logic [63:0] x);
    return x[63] ? ~x : {1'b1, x[62:0]};
  endfunction
  function automatic bit m_lt(logic [63:0] a, logic [63:0] b);
    if (m_nan(a) || m_nan(b) || (m_zero(a) && m_zero(b))) return 1'b0;
    return m_key(a) < m_key(b);
  endfunction
  function automatic bit m_eq(logic [63:0] a, logic [63:0] b);
    if (m_nan(a) || m_nan(b)) return 1'b0;
    return a == b || (m_zero(a) && m_zero(b));
  endfunction
  function automatic logic [63:0] m_class(logic [63:0] x);
    int pos;
    logic [10:0] e;
    e = x[62:52];
    if (m_snan(x))                pos = 8;
    else if (m_nan(x))            pos = 9;
    else if (e == 11'h7FF)        pos = x[63] ? 0 : 7;
    else if (e == 0 && m_zero(x)) pos = x[63] ? 3 : 4;
    else if (e == 0)              pos = x[63] ? 2 : 5;
    else                          pos = x[63] ? 1 : 6;
    return 64'd1 << pos;
  endfunction

  function automatic exp_t model(logic [2:0] g, logic [2:0] s,
                                 logic [63:0] a, logic [63:0] b, string req);
    exp_t e;
    bit snan_any, nan_any;
    e.fp = '0; e.ir = '0; e.dst = 0; e.inv = 0; e.ill = 0; e.req = req;
    snan_any = m_snan(a) || m_snan(b);
    nan_any  = m_nan(a) || m_nan(b);
    case (g)
      3'd0: case (s)
        3'd0: e.fp = {b[63], a[62:0]};
        3'd1: e.fp = {~b[63], a[62:0]};
        3'd2: e.fp = {a[63] ^ b[63], a[62:0]};
        default: e.ill = 1;
      endcase
      3'd1: case (s)
        3'd0: begin e.fp = (m_nan(b) || m_lt(a, b)) ? a : b; e.inv = snan_any; end
        3'd1: begin e.fp = (m_nan(b) || m_lt(b, a) || m_eq(b, a)) ? a : b; e.inv = snan_any; end
        default: e.ill = 1;
      endcase
      3'd2: case (s)
        3'd0: begin e.ir = 64'(m_lt(a, b) || m_eq(a, b)); e.dst = 1; e.inv = nan_any; end
        3'd1: begin e.ir = 64'(m_lt(a, b)); e.dst = 1; e.inv = nan_any; end
        3'd2: begin e.ir = 64'(m_eq(a, b)); e.dst = 1; e.inv = snan_any; end
        default: e.ill = 1;
      endcase
      3'd3: case (s)
        3'd0: begin e.ir = a; e.dst = 1; end
        3'd1: begin e.ir = m_class(a); e.dst = 1; end
        default: e.ill = 1;
      endcase
      3'd4: if (s == 0) e.fp = a; else e.ill = 1;
      default: e.ill = 1;
    endcase
    return e;
  endfunction

  task automatic issue(input logic [2:0] g, input logic [2:0] s,
                       input logic [63:0] a, input logic [63:0] b, input string req);
    valid_i = 1'b1;
    grp_i   = g;
    sub_i   = s;
    op_a_i  = a;
    op_b_i  = b;
    sb_q.push_back(model(g, s, a, b, req));
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done && valid_o) begin
      total++;
      if (sb_q.size() == 0) begin
        bad++;
        $display("FAIL R1 unexpected valid_o: actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (fp_res_o !== e.fp || int_res_o !== e.ir || int_dst_o !== e.dst ||
            invalid_o !== e.inv || illegal_o !== e.ill) begin
          bad++;
          $display("FAIL %s g=%0d s=%0d a=%h b=%h: actual fp=%h int=%h dst=%b inv=%b ill=%b expected fp=%h int=%h dst=%b inv=%b ill=%b",
                   e.req, grp_i, sub_i, op_a_i, op_b_i, fp_res_o, int_res_o, int_dst_o,
                   invalid_o, illegal_o, e.fp, e.ir, e.dst, e.inv, e.ill);
        end
      end
    end
  end

  task automatic check_direct(input bit ok, input string req, input logic [63:0] act,
                              input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_direct(valid_o == 0 && fp_res_o == 0 && int_res_o == 0 &&
                 !int_dst_o && !invalid_o && !illegal_o,
                 "R1 reset", {valid_o, fp_res_o[62:0]}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 sign injection, R3/R4/R8 min/max, R5/R6/R7 compares
    for (int i = 0; i < NVAL; i++) begin
      for (int j = 0; j < NVAL; j++) begin
        for (int s = 0; s < 3; s++) issue(3'd0, 3'(s), vals[i], vals[j], "R2");
        issue(3'd1, 3'd0, vals[i], vals[j], "R3 R8");
        issue(3'd1, 3'd1, vals[i], vals[j], "R4 R8");
        for (int s = 0; s < 3; s++)
          issue(3'd2, 3'(s), vals[i], vals[j],
                (m_zero(vals[i]) && m_zero(vals[j])) ? "R6" : "R5 R7");
      end
    end

    // R9 R10 classification and R11 moves
    for (int i = 0; i < NVAL; i++) begin
      issue(3'd3, 3'd1, vals[i], vals[(i + 3) % NVAL], "R9 R10");
      issue(3'd3, 3'd0, vals[i], '0, "R11");
      issue(3'd4, 3'd0, vals[i], vals[i] ^ 64'hFFFF, "R11");
    end
    issue(3'd3, 3'd1, 64'h0000_0000_0000_0001, '0, "R9 R10");
    issue(3'd3, 3'd1, 64'h7FF0_0000_0000_0001, '0, "R9 R10");
    issue(3'd3, 3'd1, 64'h7FF8_0000_0000_0000, '0, "R9 R10");
    issue(3'd3, 3'd1, 64'h7FE0_0000_0000_0000, '0, "R9 R10");
    issue(3'd4, 3'd0, 64'h0123_4567_89AB_CDEF, '0, "R11");

    // R12 undefined codes
    for (int g = 0; g < 8; g++)
      for (int s = 0; s < 8; s++)
        issue(3'(g), 3'(s), vals[9], vals[8], "R12");

    // R1 hold while idle
    issue(3'd4, 3'd0, 64'hDEAD_BEEF_0000_1111, '0, "R1");
    held = 64'hDEAD_BEEF_0000_1111;
    op_a_i = 64'h1111;
    grp_i  = 3'd7;
    @(negedge clk);
    @(negedge clk);
    check_direct(!valid_o && fp_res_o == held && !illegal_o, "R1 hold", fp_res_o, held);

    repeat (3) @(negedge clk);
    check_direct(sb_q.size() == 0, "R1 drained", 64'(sb_q.size()), 64'd0);
    finish_run();
  end
endmodule